// File: doc/BRIEF.md
# DMA Channel Request Front End

This block sits in front of the transfer engine of one DMA channel. It keeps a copy of the channel's control settings, written through a simple write strobe. Those settings are an enable, a request-source code, a detection mode for the external request pin and a burst/cycle-steal choice. From them the block decides when the engine is asked to move one transfer unit. It also decides whether the engine keeps the bus between units. The engine answers every unit with a one-cycle `xfer_done` pulse.

There are three request sources. The first is an external pin that can arrive at any time; it passes through a two-flop synchronizer and is then watched at a low or high level, or for a falling or rising edge. The second is an auto-request that asks all the time. The third is a one-cycle peripheral strobe. The parameter `CHAN_IDX` gives the channel's position, and it decides which settings mean anything: only low-numbered channels can use the pin, and only a slightly larger group can use burst. A settings write that is not allowed raises `cfg_err`, and the channel then stays quiet until the next write.

A state machine drives the outputs. Its states are `ST_OFF` (channel stopped or faulted), `ST_IDLE` (waiting for a request), `ST_XFER` (a unit is requested and the bus is held) and `ST_HOLD` (burst only: the bus is still held between units). The transitions are as follows. OFF→IDLE happens when the channel runs. IDLE→XFER happens on a request. XFER→IDLE happens on done in cycle-steal, and XFER→HOLD on done in burst. HOLD→XFER happens on the next request. HOLD→IDLE happens when a level request goes inactive. Any state goes to OFF when the channel stops running. Running means enabled with no fault.

Top module: `dma_req_front`

## Requirements
- R1: The source code is 4'b0000 for the external pin, 4'b0100 for auto-request and 4'b1000 for the peripheral strobe. Any other code written raises `cfg_err`, and the channel makes no request.
- R2: Pin detection mode bit 1 selects polarity (1 = high/rising) and bit 0 selects edge detection. Modes 2'b00 (low level) and 2'b10 (high level) raise `xfer_req` on the third rising clock edge after the pin reaches its active level.
- R3: Modes 2'b01 (falling) and 2'b11 (rising) latch a detected edge as pending. The pending edge is cleared by `xfer_done`, and several edges seen before that done count as one request.
- R4: In a level mode, the pin is checked again after each `xfer_done`. In cycle-steal, if the level is still active, `xfer_req` comes back after one low cycle.
- R5: Auto-request raises `xfer_req` on the third edge after the enabling write and keeps asking while the channel runs.
- R6: On a channel with `CHAN_IDX` above 3, source 4'b0000 is legal but never produces a request.
- R7: On a channel with `CHAN_IDX` above 5, the burst bit is ignored: the channel works in cycle-steal and raises no error.
- R8: On channels 0 to 5, peripheral source with burst set raises `cfg_err`.
- R9: A write that tries to change the source while the channel is enabled keeps the old source and raises `cfg_err`.
- R10: `cfg_err` stays set until the next write, which clears it if that write is allowed. While it is set, `xfer_req` and `hold_bus` are low from the second cycle on.
- R11: In cycle-steal, `hold_bus` follows `xfer_req`, and both drop in the cycle after `xfer_done`.
- R12: In burst, `hold_bus` stays high between units. It drops when the channel stops or when a level-mode pin goes inactive.
- R13: A peripheral strobe is latched as pending until `xfer_done`. The detection mode has no effect on the auto and peripheral sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the settings below |
| cfg_en | input | 1 | Channel enable value to write |
| cfg_src | input | 4 | Request source code to write |
| cfg_det | input | 2 | Pin detection mode to write |
| cfg_burst | input | 1 | Burst (1) or cycle-steal (0) to write |
| ext_req_in | input | 1 | Asynchronous external request pin |
| periph_req | input | 1 | One-cycle peripheral request strobe |
| xfer_done | input | 1 | Engine finished one transfer unit |
| xfer_req | output | 1 | Request for one transfer unit |
| hold_bus | output | 1 | Engine keeps the bus |
| cfg_err | output | 1 | Setting not allowed |

## Verification
The bench builds two copies side by side and drives both from the same stimulus. The first copy uses `CHAN_IDX` = 1, so the pin source and burst are both allowed. The second uses `CHAN_IDX` = 8, where the pin source must stay silent and the burst bit must be ignored. The same writes therefore show R6 and R7 against R2, R8 and R12 in one run. Directed phases cover level and edge detection, the burst gap, the source lock and clearing an error. A random phase then mixes writes, pin activity, strobes and done pulses, and checks every cycle against a model in the bench.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

    localparam logic [3:0] SRC_EXT  = 4'b0000;
    localparam logic [3:0] SRC_AUTO = 4'b0100;
    localparam logic [3:0] SRC_PERI = 4'b1000;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_IDLE = 2'd1,
        ST_XFER = 2'd2,
        ST_HOLD = 2'd3
    } req_state_e;

    function automatic logic src_known(input logic [3:0] code);
        return (code == SRC_EXT) || (code == SRC_AUTO) || (code == SRC_PERI);
    endfunction

endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= async_in;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/dma_req_cfg.sv
module dma_req_cfg
    import dma_req_pkg::*;
#(
    parameter bit BURST_OK = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic       cfg_en,
    input  logic [3:0] cfg_src,
    input  logic [1:0] cfg_det,
    input  logic       cfg_burst,
    output logic       ctl_en,
    output logic [3:0] ctl_src,
    output logic [1:0] ctl_det,
    output logic       ctl_burst_eff,
    output logic       ctl_err
);
    logic       burst_q;
    logic       src_locked;
    logic [3:0] src_next;
    logic       bad_combo;
    logic       fault;

    // Source may only move while the channel is stopped.
    always_comb begin
        src_locked = ctl_en && (cfg_src != ctl_src);
        src_next   = src_locked ? ctl_src : cfg_src;
        bad_combo  = BURST_OK && cfg_burst && (src_next == SRC_PERI);
        fault      = src_locked || !src_known(src_next) || bad_combo;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_en  <= 1'b0;
            ctl_src <= SRC_EXT;
            ctl_det <= 2'b00;
            burst_q <= 1'b0;
            ctl_err <= 1'b0;
        end else if (cfg_wr) begin
            ctl_en  <= cfg_en;
            ctl_src <= src_next;
            ctl_det <= cfg_det;
            burst_q <= cfg_burst;
            ctl_err <= fault;
        end
    end

    assign ctl_burst_eff = BURST_OK && burst_q;
endmodule

// File: rtl/dma_req_detect.sv
module dma_req_detect
    import dma_req_pkg::*;
#(
    parameter bit EXT_OK = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [3:0] src,
    input  logic [1:0] det,
    input  logic       ext_s,
    input  logic       periph_req,
    input  logic       xfer_done,
    output logic       want,
    output logic       lvl_mode
);
    logic ext_d;
    logic pend_q;
    logic is_ext, is_auto, is_peri;
    logic lvl_act, edge_hit, event_in;

    always_comb begin
        is_ext   = EXT_OK && (src == SRC_EXT);
        is_auto  = (src == SRC_AUTO);
        is_peri  = (src == SRC_PERI);
        lvl_act  = det[1] ? ext_s : !ext_s;
        edge_hit = det[1] ? (ext_s && !ext_d) : (!ext_s && ext_d);
        event_in = (is_ext && det[0] && edge_hit) || (is_peri && periph_req);
        lvl_mode = is_ext && !det[0];
        want     = is_auto
                 || (is_peri && (pend_q || periph_req))
                 || (is_ext && (det[0] ? (pend_q || edge_hit) : lvl_act));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_d  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            ext_d  <= ext_s;
            pend_q <= run && (event_in || (pend_q && !xfer_done));
        end
    end
endmodule

// File: rtl/dma_req_fsm.sv
module dma_req_fsm
    import dma_req_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic want,
    input  logic burst_eff,
    input  logic lvl_mode,
    input  logic xfer_done,
    output logic xfer_req,
    output logic hold_bus
);
    req_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:  if (run) state_nx = ST_IDLE;
            ST_IDLE: begin
                if (!run)      state_nx = ST_OFF;
                else if (want) state_nx = ST_XFER;
            end
            ST_XFER: begin
                if (!run)           state_nx = ST_OFF;
                else if (xfer_done) state_nx = burst_eff ? ST_HOLD : ST_IDLE;
            end
            ST_HOLD: begin
                if (!run)          state_nx = ST_OFF;
                else if (want)     state_nx = ST_XFER;
                else if (lvl_mode) state_nx = ST_IDLE;
            end
            default: state_nx = ST_OFF;
        endcase
    end

    always_comb begin
        xfer_req = 1'b0;
        hold_bus = 1'b0;
        unique case (state)
            ST_OFF, ST_IDLE: ;
            ST_XFER: begin
                xfer_req = 1'b1;
                hold_bus = 1'b1;
            end
            ST_HOLD: hold_bus = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/dma_req_front.sv
module dma_req_front
    import dma_req_pkg::*;
#(
    parameter int CHAN_IDX      = 0,
    parameter int EXT_LAST_CH   = 3,
    parameter int BURST_LAST_CH = 5,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic       cfg_en,
    input  logic [3:0] cfg_src,
    input  logic [1:0] cfg_det,
    input  logic       cfg_burst,
    input  logic       ext_req_in,
    input  logic       periph_req,
    input  logic       xfer_done,
    output logic       xfer_req,
    output logic       hold_bus,
    output logic       cfg_err
);
    localparam bit EXT_OK   = (CHAN_IDX <= EXT_LAST_CH);
    localparam bit BURST_OK = (CHAN_IDX <= BURST_LAST_CH);

    logic       ctl_en;
    logic [3:0] ctl_src;
    logic [1:0] ctl_det;
    logic       ctl_burst_eff;
    logic       ctl_err;
    logic       run;
    logic       ext_s;
    logic       want;
    logic       lvl_mode;

    dma_req_cfg #(.BURST_OK(BURST_OK)) u_cfg (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_wr        (cfg_wr),
        .cfg_en        (cfg_en),
        .cfg_src       (cfg_src),
        .cfg_det       (cfg_det),
        .cfg_burst     (cfg_burst),
        .ctl_en        (ctl_en),
        .ctl_src       (ctl_src),
        .ctl_det       (ctl_det),
        .ctl_burst_eff (ctl_burst_eff),
        .ctl_err       (ctl_err)
    );

    dma_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_req_in),
        .sync_out (ext_s)
    );

    assign run = ctl_en && !ctl_err;

    dma_req_detect #(.EXT_OK(EXT_OK)) u_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .src        (ctl_src),
        .det        (ctl_det),
        .ext_s      (ext_s),
        .periph_req (periph_req),
        .xfer_done  (xfer_done),
        .want       (want),
        .lvl_mode   (lvl_mode)
    );

    dma_req_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .want      (want),
        .burst_eff (ctl_burst_eff),
        .lvl_mode  (lvl_mode),
        .xfer_done (xfer_done),
        .xfer_req  (xfer_req),
        .hold_bus  (hold_bus)
    );

    assign cfg_err = ctl_err;
endmodule

// File: rtl/dma_req_front_chk.sv
module dma_req_front_chk
    import dma_req_pkg::*;
#(
    parameter int CHAN_IDX      = 0,
    parameter int EXT_LAST_CH   = 3,
    parameter int BURST_LAST_CH = 5
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_wr,
    input logic [3:0] cfg_src,
    input logic       xfer_done,
    input logic       xfer_req,
    input logic       hold_bus,
    input logic       cfg_err,
    input logic       ctl_en,
    input logic [3:0] ctl_src,
    input logic       ctl_burst_eff
);
    assert_hold_covers_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> hold_bus);

    assert_steal_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && xfer_done && !ctl_burst_eff) |=> !xfer_req);

    assert_err_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && $past(cfg_err)) |-> (!xfer_req && !hold_bus));

    assert_src_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_en && cfg_wr && (cfg_src != ctl_src)) |=> (cfg_err && $stable(ctl_src)));

    assert_no_ext_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((CHAN_IDX > EXT_LAST_CH) && (ctl_src == SRC_EXT) && ($past(ctl_src) == SRC_EXT))
        |-> !xfer_req);

    assert_burst_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((CHAN_IDX > BURST_LAST_CH) && xfer_req && xfer_done) |=> !hold_bus);
endmodule

bind dma_req_front dma_req_front_chk #(
    .CHAN_IDX      (CHAN_IDX),
    .EXT_LAST_CH   (EXT_LAST_CH),
    .BURST_LAST_CH (BURST_LAST_CH)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_wr        (cfg_wr),
    .cfg_src       (cfg_src),
    .xfer_done     (xfer_done),
    .xfer_req      (xfer_req),
    .hold_bus      (hold_bus),
    .cfg_err       (cfg_err),
    .ctl_en        (ctl_en),
    .ctl_src       (ctl_src),
    .ctl_burst_eff (ctl_burst_eff)
);

// File: tb/dma_req_front_tb.sv
module dma_req_front_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    localparam int RAND_CYC   = 3000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic       cfg_en = 1'b0;
    logic [3:0] cfg_src = 4'b0000;
    logic [1:0] cfg_det = 2'b00;
    logic       cfg_burst = 1'b0;
    logic       ext_req_in = 1'b0;
    logic       periph_req = 1'b0;
    logic       xfer_done = 1'b0;
    logic       req0, hold0, err0;
    logic       req1, hold1, err1;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_req_front #(.CHAN_IDX(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
        .cfg_src(cfg_src), .cfg_det(cfg_det), .cfg_burst(cfg_burst),
        .ext_req_in(ext_req_in), .periph_req(periph_req), .xfer_done(xfer_done),
        .xfer_req(req0), .hold_bus(hold0), .cfg_err(err0)
    );

    dma_req_front #(.CHAN_IDX(8)) u_dut_hi (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
        .cfg_src(cfg_src), .cfg_det(cfg_det), .cfg_burst(cfg_burst),
        .ext_req_in(ext_req_in), .periph_req(periph_req), .xfer_done(xfer_done),
        .xfer_req(req1), .hold_bus(hold1), .cfg_err(err1)
    );

    // Bench model, one entry per copy (0: channel 1, 1: channel 8)
    int       m_chan [2] = '{1, 8};
    bit       m_en [2], m_err [2], m_burst [2];
    bit [3:0] m_src [2];
    bit [1:0] m_det [2];
    bit       m_s1 [2], m_s2 [2], m_d [2], m_pend [2];
    int       m_st [2];

    task automatic model_reset();
        for (int i = 0; i < 2; i++) begin
            m_en[i] = 0; m_err[i] = 0; m_burst[i] = 0; m_src[i] = 4'b0000; m_det[i] = 2'b00;
            m_s1[i] = 0; m_s2[i] = 0; m_d[i] = 0; m_pend[i] = 0; m_st[i] = 0;
        end
    endtask

    task automatic model_step(int i);
        bit run, ext_ok, burst_ok, is_ext, is_auto, is_peri, lvl, hit, evt, want, lmode, beff;
        bit chg, bad;
        bit [3:0] nsrc;
        int nst;
        run      = m_en[i] && !m_err[i];
        ext_ok   = (m_chan[i] <= 3);
        burst_ok = (m_chan[i] <= 5);
        is_ext   = ext_ok && (m_src[i] == 4'b0000);
        is_auto  = (m_src[i] == 4'b0100);
        is_peri  = (m_src[i] == 4'b1000);
        lvl      = m_det[i][1] ? m_s2[i] : !m_s2[i];
        hit      = m_det[i][1] ? (m_s2[i] && !m_d[i]) : (!m_s2[i] && m_d[i]);
        evt      = (is_ext && m_det[i][0] && hit) || (is_peri && periph_req);
        want     = is_auto || (is_peri && (m_pend[i] || periph_req))
                 || (is_ext && (m_det[i][0] ? (m_pend[i] || hit) : lvl));
        lmode    = is_ext && !m_det[i][0];
        beff     = m_burst[i] && burst_ok;
        case (m_st[i])
            0: nst = run ? 1 : 0;
            1: nst = !run ? 0 : (want ? 2 : 1);
            2: nst = !run ? 0 : (xfer_done ? (beff ? 3 : 1) : 2);
            default: nst = !run ? 0 : (want ? 2 : (lmode ? 1 : 3));
        endcase
        m_st[i]   = nst;
        m_pend[i] = run && (evt || (m_pend[i] && !xfer_done));
        m_d[i]    = m_s2[i];
        m_s2[i]   = m_s1[i];
        m_s1[i]   = ext_req_in;
        if (cfg_wr) begin
            chg  = m_en[i] && (cfg_src != m_src[i]);
            nsrc = chg ? m_src[i] : cfg_src;
            bad  = !(nsrc == 4'b0000 || nsrc == 4'b0100 || nsrc == 4'b1000)
                 || (burst_ok && cfg_burst && nsrc == 4'b1000);
            m_err[i]   = chg || bad;
            m_src[i]   = nsrc;
            m_en[i]    = cfg_en;
            m_det[i]   = cfg_det;
            m_burst[i] = cfg_burst;
        end
    endtask

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2 R3 R4 R5 R6 R13 xfer_req ch1", req0, m_st[0] == 2);
        chk("R11 R12 hold_bus ch1", hold0, m_st[0] >= 2);
        chk("R1 R8 R9 R10 cfg_err ch1", err0, m_err[0]);
        chk("R2 R3 R4 R5 R6 R13 xfer_req ch8", req1, m_st[1] == 2);
        chk("R7 R11 R12 hold_bus ch8", hold1, m_st[1] >= 2);
        chk("R1 R7 R9 R10 cfg_err ch8", err1, m_err[1]);
    endtask

    // Inputs are set before the call; they are consumed by the next edge.
    task automatic cycle();
        model_step(0);
        model_step(1);
        @(negedge clk);
        compare_all();
    endtask

    task automatic write_cfg(bit en, bit [3:0] src, bit [1:0] det, bit burst);
        cfg_wr = 1; cfg_en = en; cfg_src = src; cfg_det = det; cfg_burst = burst;
        cycle();
        cfg_wr = 0;
    endtask

    task automatic pulse_done();
        xfer_done = 1;
        cycle();
        xfer_done = 0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h1d5e_a7c3));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("reset xfer_req", req0 | req1, 1'b0);
        chk("reset hold_bus", hold0 | hold1, 1'b0);
        chk("reset cfg_err", err0 | err1, 1'b0);

        // R5: auto-request, 3 edges after the enabling write
        write_cfg(1, 4'b0100, 2'b11, 0);
        cycle();
        chk("R5 auto not yet", req0, 1'b0);
        cycle();
        chk("R5 auto request ch1", req0, 1'b1);
        chk("R5 auto request ch8", req1, 1'b1);
        pulse_done();
        chk("R11 gap after done req", req0, 1'b0);
        chk("R11 gap after done hold", hold0, 1'b0);
        cycle();
        chk("R5 auto returns", req0, 1'b1);

        // R9: source change while enabled is refused
        write_cfg(1, 4'b1000, 2'b00, 0);
        chk("R9 lock error ch1", err0, 1'b1);
        chk("R9 lock error ch8", err1, 1'b1);
        cycle();
        cycle();
        chk("R10 quiet under error", req0 | hold0, 1'b0);
        // Same source kept: rewriting 0100 is not a change, so error clears
        write_cfg(1, 4'b0100, 2'b00, 0);
        chk("R10 R9 error cleared", err0, 1'b0);
        cycle();
        cycle();
        chk("R10 auto resumes", req0, 1'b1);

        // R1: unknown source code
        write_cfg(0, 4'b0100, 2'b00, 0);
        write_cfg(0, 4'b0010, 2'b00, 0);
        chk("R1 illegal code ch1", err0, 1'b1);
        chk("R1 illegal code ch8", err1, 1'b1);

        // R8 / R7: peripheral with burst
        write_cfg(1, 4'b1000, 2'b00, 1);
        chk("R8 periph burst ch1", err0, 1'b1);
        chk("R7 periph burst ignored ch8", err1, 1'b0);
        cycle();
        periph_req = 1;
        cycle();
        periph_req = 0;
        chk("R13 strobe request ch8", req1, 1'b1);
        chk("R8 no request ch1", req0, 1'b0);
        pulse_done();
        chk("R7 cycle-steal ch8 hold drop", hold1, 1'b0);
        cycle();
        chk("R13 pending cleared ch8", req1, 1'b0);

        // R2 / R12 / R6: high-level pin source in burst
        write_cfg(0, 4'b1000, 2'b10, 0);
        write_cfg(0, 4'b0000, 2'b10, 1);
        write_cfg(1, 4'b0000, 2'b10, 1);
        cycle();
        cycle();
        chk("R2 inactive pin", req0, 1'b0);
        ext_req_in = 1;
        cycle();
        cycle();
        chk("R2 two edges not yet", req0, 1'b0);
        cycle();
        chk("R2 high level request ch1", req0, 1'b1);
        chk("R6 pin ignored ch8", req1, 1'b0);
        chk("R6 no error ch8", err1, 1'b0);
        pulse_done();
        chk("R12 burst gap req", req0, 1'b0);
        chk("R12 burst gap hold", hold0, 1'b1);
        cycle();
        chk("R4 level rechecked", req0, 1'b1);
        ext_req_in = 0;
        cycle();
        cycle();
        cycle();
        pulse_done();
        chk("R12 gap hold before recheck", hold0, 1'b1);
        cycle();
        chk("R12 level inactive drops hold", hold0, 1'b0);

        // R3: rising edge, pending cleared by done
        write_cfg(0, 4'b0000, 2'b11, 0);
        write_cfg(1, 4'b0000, 2'b11, 0);
        cycle();
        cycle();
        chk("R3 no edge no request", req0, 1'b0);
        ext_req_in = 1;
        cycle();
        cycle();
        cycle();
        chk("R3 rising edge request", req0, 1'b1);
        pulse_done();
        cycle();
        cycle();
        chk("R3 pending cleared by done", req0, 1'b0);

        // Random phase
        write_cfg(0, 4'b0000, 2'b00, 0);
        for (int n = 0; n < RAND_CYC; n++) begin
            int r;
            r = $urandom % 10;
            cfg_wr  = ($urandom % 20) == 0;
            cfg_en  = ($urandom % 5) != 0;
            cfg_src = (r < 3) ? 4'b0000 : (r < 6) ? 4'b0100 : (r < 9) ? 4'b1000
                                                  : 4'($urandom % 16);
            cfg_det   = 2'($urandom % 4);
            cfg_burst = ($urandom % 3) == 0;
            if (($urandom % 4) == 0) ext_req_in = ~ext_req_in;
            periph_req = ($urandom % 6) == 0;
            xfer_done  = (req0 | req1) ? (($urandom % 3) == 0) : (($urandom % 16) == 0);
            cycle();
        end
        cfg_wr = 0; periph_req = 0; xfer_done = 0;
        finish_run();
    end
endmodule